// File: doc/BRIEF.md
# Per-Page ECC Error Report Aggregator

While a flash page is read, a BCH decoder produces one result for each packet of the page. This block gathers those results and turns them into one 32-bit error-report word for the page. The first packet (index 0) keeps its own corrected-bit count and success flag. Every later packet is folded into one running maximum of corrected bits and one combined success flag. A success flag reads 1 when decoding worked, so a cleared flag means failure.

A page opens with a start strobe and closes with an end strobe. On the end strobe the report word and a page-empty status bit are loaded together, and a one-cycle done pulse marks the update. When the transfer logic reports that the page was erased (empty), both count fields are forced to zero and both flags are forced to 1. The decoder itself is not part of this block.

Top module: `ecc_page_report`

## Requirements
- R1: After reset, `report_o`, `empty_o` and `done_o` are all zero.
- R2: Report bits 5:0 hold the corrected-bit count of the packet with index 0. Bit 7 is 1 when that packet decoded successfully and 0 when it failed.
- R3: Report bits 13:8 hold the largest corrected-bit count over all packets with a nonzero index in the page. This is a maximum, not a sum.
- R4: Report bit 15 is 1 only when every packet with a nonzero index decoded successfully. A page with no such packet reports 1.
- R5: Any count above 63 is reported as 63 in both count fields.
- R6: `sop_i` starts a fresh page. Both counts are cleared and both flags are set to 1, so nothing from earlier pages carries over.
- R7: The cycle after `eop_i` is high, `report_o` and `empty_o` take the new page values and `done_o` is high for exactly that cycle. Otherwise `report_o` and `empty_o` keep their values.
- R8: If `page_empty_i` is high together with `eop_i`, `empty_o` becomes 1 and the report is 0x00008080: counts are zero and flags are 1.
- R9: Within a single cycle, `sop_i` acts first, then the packet result, then `eop_i`. A packet presented with `eop_i` is included in that page's report. A one-cycle page (sop, packet and eop together) is valid.
- R10: Report bits 6, 14 and 31:16 are always 0.
- R11: A packet result with `pkt_vld_i` low has no effect on the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | Start-of-page strobe |
| eop_i | input | 1 | End-of-page strobe |
| page_empty_i | input | 1 | Erased-page indication, sampled with `eop_i` |
| pkt_vld_i | input | 1 | Packet result valid |
| pkt_idx_i | input | IDX_W | Packet index within the page |
| pkt_cnt_i | input | CNT_IN_W | Corrected-bit count from the decoder |
| pkt_ok_i | input | 1 | Decoder success flag (1 = success) |
| report_o | output | 32 | Page error-report word |
| empty_o | output | 1 | Page-empty status of the last reported page |
| done_o | output | 1 | One-cycle pulse when the report updates |

## Verification
The bench builds the block with its defaults: an 8-bit count input and a 4-bit packet index. The 8-bit count lets the random stimulus push counts well past 63, so saturation is exercised in both count fields. The 4-bit index allows pages of up to sixteen packets. Random pages merge sop and eop with neighbouring packets, insert idle cycles carrying invalid garbage, and sometimes send a page-empty indication. This reaches every ordering corner of R9 and the ignore rule of R11.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

  // Field layout of the report word; a downstream reader decodes these positions.
  localparam int RPT_W      = 32;
  localparam int CNT_W      = 6;
  localparam int P0_CNT_LSB = 0;
  localparam int P0_OK_BIT  = 7;
  localparam int PN_CNT_LSB = 8;
  localparam int PN_OK_BIT  = 15;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef struct packed {
    logic [CNT_W-1:0] p0_cnt;
    logic             p0_ok;
    logic [CNT_W-1:0] pn_max;
    logic             pn_ok;
  } acc_t;

  function automatic acc_t acc_init();
    acc_t a;
    a.p0_cnt = '0;
    a.p0_ok  = 1'b1;
    a.pn_max = '0;
    a.pn_ok  = 1'b1;
    return a;
  endfunction

  function automatic logic [RPT_W-1:0] pack_report(acc_t a);
    logic [RPT_W-1:0] w;
    w = '0;
    w[P0_CNT_LSB +: CNT_W] = a.p0_cnt;
    w[P0_OK_BIT]           = a.p0_ok;
    w[PN_CNT_LSB +: CNT_W] = a.pn_max;
    w[PN_OK_BIT]           = a.pn_ok;
    return w;
  endfunction

endpackage

// File: rtl/ecc_rpt_sat.sv
module ecc_rpt_sat #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  cnt_i,
  output logic [OUT_W-1:0] cnt_o
);

  generate
    if (IN_W > OUT_W) begin : g_clip
      logic over;
      assign over  = |cnt_i[IN_W-1:OUT_W];
      assign cnt_o = over ? {OUT_W{1'b1}} : cnt_i[OUT_W-1:0];
    end else begin : g_pass
      assign cnt_o = OUT_W'(cnt_i);
    end
  endgenerate

endmodule

// File: rtl/ecc_rpt_fold.sv
module ecc_rpt_fold
  import ecc_rpt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  acc_t             acc_i,
  input  logic             sop_i,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ok_i,
  output acc_t             acc_o
);

  acc_t base;

  always_comb begin
    base  = sop_i ? acc_init() : acc_i;
    acc_o = base;
    if (vld_i) begin
      if (idx_i == '0) begin
        acc_o.p0_cnt = cnt_i;
        acc_o.p0_ok  = ok_i;
      end else begin
        if (cnt_i > base.pn_max) acc_o.pn_max = cnt_i;
        acc_o.pn_ok = base.pn_ok & ok_i;
      end
    end
  end

endmodule

// File: rtl/ecc_rpt_out.sv
module ecc_rpt_out
  import ecc_rpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             eop_i,
  input  logic             empty_i,
  input  acc_t             acc_i,
  output logic [RPT_W-1:0] report_o,
  output logic             empty_o,
  output logic             done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      report_o <= '0;
      empty_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= eop_i;
      if (eop_i) begin
        empty_o  <= empty_i;
        report_o <= empty_i ? pack_report(acc_init()) : pack_report(acc_i);
      end
    end
  end

  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(eop_i)); // R7

  AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !eop_i |=> ($stable(report_o) && $stable(empty_o))); // R7

  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> (report_o[PN_CNT_LSB +: CNT_W] == '0 && report_o[P0_CNT_LSB +: CNT_W] == '0
                 && report_o[P0_OK_BIT] && report_o[PN_OK_BIT])); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (report_o[RPT_W-1:16] == '0 && !report_o[6] && !report_o[14])); // R10

endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report
  import ecc_rpt_pkg::*;
#(
  parameter int CNT_IN_W = 8,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sop_i,
  input  logic                eop_i,
  input  logic                page_empty_i,
  input  logic                pkt_vld_i,
  input  logic [IDX_W-1:0]    pkt_idx_i,
  input  logic [CNT_IN_W-1:0] pkt_cnt_i,
  input  logic                pkt_ok_i,
  output logic [31:0]         report_o,
  output logic                empty_o,
  output logic                done_o
);

  logic [CNT_W-1:0] cnt_sat;
  acc_t             acc_q;
  acc_t             acc_d;

  ecc_rpt_sat #(.IN_W(CNT_IN_W), .OUT_W(CNT_W)) i_sat (
    .cnt_i (pkt_cnt_i),
    .cnt_o (cnt_sat)
  );

  ecc_rpt_fold #(.IDX_W(IDX_W)) i_fold (
    .acc_i (acc_q),
    .sop_i (sop_i),
    .vld_i (pkt_vld_i),
    .idx_i (pkt_idx_i),
    .cnt_i (cnt_sat),
    .ok_i  (pkt_ok_i),
    .acc_o (acc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_q <= acc_init();
    else     acc_q <= acc_d;
  end

  ecc_rpt_out i_out (
    .clk      (clk),
    .rst      (rst),
    .eop_i    (eop_i),
    .empty_i  (page_empty_i),
    .acc_i    (acc_d),
    .report_o (report_o),
    .empty_o  (empty_o),
    .done_o   (done_o)
  );

  AST_MAX_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    !sop_i |=> (acc_q.pn_max >= $past(acc_q.pn_max))); // R3

  AST_OK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!sop_i && !acc_q.pn_ok) |=> !acc_q.pn_ok); // R4

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!sop_i && !pkt_vld_i) |=> $stable(acc_q)); // R11

  AST_SOP_FRESH: assert property (@(posedge clk) disable iff (rst)
    (sop_i && !pkt_vld_i) |=> (acc_q == acc_init())); // R6

endmodule

// File: tb/test_ecc_page_report.sv
`timescale 1ns/1ps
module test_ecc_page_report;

  localparam int CNT_IN_W = 8;
  localparam int IDX_W    = 4;

  logic                clk = 1'b0;
  logic                rst;
  logic                sop, eop, pg_empty, vld, ok;
  logic [IDX_W-1:0]    idx;
  logic [CNT_IN_W-1:0] cnt;
  logic [31:0]         report;
  logic                empty, done;

  int checks = 0;
  int fails  = 0;

  int cnt_a [16];
  int idx_a [16];
  bit ok_a  [16];

  always #4 clk = ~clk;

  ecc_page_report #(.CNT_IN_W(CNT_IN_W), .IDX_W(IDX_W)) i_ecc_page_report (
    .clk(clk), .rst(rst), .sop_i(sop), .eop_i(eop), .page_empty_i(pg_empty),
    .pkt_vld_i(vld), .pkt_idx_i(idx), .pkt_cnt_i(cnt), .pkt_ok_i(ok),
    .report_o(report), .empty_o(empty), .done_o(done)
  );

  function automatic int sat63(int c);
    return (c > 63) ? 63 : c;
  endfunction

  function automatic logic [31:0] mk_report(int p0c, bit p0ok, int pnm, bit pnok);
    logic [31:0] w;
    w = '0;
    w[5:0]  = 6'(p0c);
    w[7]    = p0ok;
    w[13:8] = 6'(pnm);
    w[15]   = pnok;
    return w;
  endfunction

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sop = 0; eop = 0; pg_empty = 0; vld = 0;
    idx = IDX_W'($urandom);
    cnt = CNT_IN_W'($urandom);
    ok  = 1'($urandom);
  endtask

  task automatic put_pkt(input int i);
    vld = 1; idx = IDX_W'(idx_a[i]); cnt = CNT_IN_W'(cnt_a[i]); ok = ok_a[i];
  endtask

  // Drive one page and check the resulting report (R2-R11).
  task automatic run_page(input int n, input bit m_sop, input bit m_eop, input bit is_empty);
    int  p0c = 0, pnm = 0;
    bit  p0ok = 1, pnok = 1, eop_sent = 0;
    int  k = 0;
    logic [31:0] exp, held;
    for (int i = 0; i < n; i++) begin
      if (idx_a[i] == 0) begin p0c = sat63(cnt_a[i]); p0ok = ok_a[i]; end
      else begin
        if (sat63(cnt_a[i]) > pnm) pnm = sat63(cnt_a[i]);
        pnok = pnok & ok_a[i];
      end
    end
    exp = is_empty ? 32'h0000_8080 : mk_report(p0c, p0ok, pnm, pnok);

    @(negedge clk);
    idle_inputs();
    sop = 1;
    if (m_sop && n > 0) begin put_pkt(0); k = 1; end
    if (m_eop && n == k) begin eop = 1; pg_empty = is_empty; eop_sent = 1; end
    for (int i = k; i < n; i++) begin
      if ($urandom_range(3) == 0) begin
        @(negedge clk); idle_inputs();     // invalid garbage, R11
      end
      @(negedge clk); idle_inputs();
      put_pkt(i);
      if (m_eop && i == n - 1) begin eop = 1; pg_empty = is_empty; eop_sent = 1; end
    end
    if (!eop_sent) begin
      @(negedge clk); idle_inputs();
      eop = 1; pg_empty = is_empty;
    end
    @(negedge clk); idle_inputs();
    chk(done === 1'b1, "R7 done pulse", {31'b0, done}, 32'd1);
    chk(report === exp, "R2/R3/R4/R5/R8/R9 report", report, exp);
    chk(empty === is_empty, "R8 empty_o", {31'b0, empty}, {31'b0, is_empty});
    chk((report & 32'hFFFF_4040) == 0, "R10 reserved bits", report, report & 32'h0000_BFBF);
    held = report;
    @(negedge clk);
    chk(done === 1'b0, "R7 single-cycle done", {31'b0, done}, 32'd0);
    chk(report === held, "R7 report holds", report, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(report === 0 && empty === 0 && done === 0, "R1 reset state",
        {report[31:2], empty, done}, 32'd0);

    // Directed: maximum, not sum (R2, R3, R4)
    idx_a[0]=0; cnt_a[0]=5; ok_a[0]=1;
    idx_a[1]=1; cnt_a[1]=2; ok_a[1]=1;
    idx_a[2]=2; cnt_a[2]=9; ok_a[2]=1;
    idx_a[3]=3; cnt_a[3]=4; ok_a[3]=1;
    run_page(4, 0, 0, 0);
    chk(report === 32'h0000_8985, "R3 max of later packets", report, 32'h0000_8985);

    // Later packet fails (R4); packet 0 fails (R2)
    ok_a[2] = 0;
    run_page(4, 1, 1, 0);
    chk(report[15] === 1'b0, "R4 later failure clears bit15", report, report & ~32'h8000);
    ok_a[2] = 1; ok_a[0] = 0;
    run_page(4, 0, 1, 0);
    chk(report[7] === 1'b0 && report[15] === 1'b1, "R2 packet0 failure", report, 32'h0000_8905);

    // Saturation (R5)
    cnt_a[0] = 200; ok_a[0] = 1; cnt_a[3] = 64;
    run_page(4, 0, 0, 0);
    chk(report === 32'h0000_BFBF, "R5 saturation", report, 32'h0000_BFBF);

    // Only packet 0 after a failing page: fresh state (R6, R4)
    ok_a[1] = 0;
    run_page(2, 0, 0, 0);
    run_page(1, 0, 0, 0);
    chk(report === 32'h0000_80BF, "R6 fresh page", report, 32'h0000_80BF);

    // Empty page overrides (R8)
    run_page(4, 0, 0, 1);
    chk(report === 32'h0000_8080 && empty === 1'b1, "R8 empty page", report, 32'h0000_8080);

    // One-cycle page (R9)
    idx_a[0] = 5; cnt_a[0] = 17; ok_a[0] = 0;
    run_page(1, 1, 1, 0);
    chk(report === 32'h0000_1180, "R9 single-cycle page", report, 32'h0000_1180);

    // Constrained random pages
    for (int p = 0; p < 300; p++) begin
      int n = $urandom_range(16);
      for (int i = 0; i < n; i++) begin
        idx_a[i] = (i == 0) ? 0 : $urandom_range(15, 1);
        cnt_a[i] = ($urandom_range(3) == 0) ? $urandom_range(255) : $urandom_range(40);
        ok_a[i]  = ($urandom_range(7) != 0);
      end
      run_page(n, 1'($urandom), 1'($urandom), ($urandom_range(9) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule